// File: doc/BRIEF.md
# Boundary-Scan Test Port for a Synchronous Memory

This block is the serial test logic of a memory device. It follows the IEEE 1149.1 controller protocol. A test clock advances a sixteen-state controller, and a mode-select input steers it. The controller routes a serial input into one of four shift paths and sends the end bit of that path to a serial output. The paths are a 3-bit instruction register, a 1-bit pass-through cell, a 32-bit identity word and a 70-bit pin-sampling chain.

The instruction latched in the instruction register selects the data path. Code 1 reads the identity word. Codes 2 and 4 capture the sampled pin vector. All other codes, including the private code 5, use the 1-bit pass-through. Code 2 also asks the memory to float its data pins for as long as the code stays latched.

The controller has sixteen states: Reset, Idle, DR-select, DR-capture, DR-shift, DR-exit1, DR-pause, DR-exit2, DR-update, IR-select, IR-capture, IR-shift, IR-exit1, IR-pause, IR-exit2 and IR-update. The transitions use the mode input: 1 / 0.
- Reset goes to Reset / Idle.
- Idle goes to DR-select / Idle.
- DR-select goes to IR-select / DR-capture.
- IR-select goes to Reset / IR-capture.
- Capture goes to exit1 / shift.
- Shift goes to exit1 / shift.
- Exit1 goes to update / pause.
- Pause goes to exit2 / pause.
- Exit2 goes to update / shift.
- Update goes to DR-select / Idle.

The last five rules apply to both the DR and the IR group.

Top module: `mem_test_port`

## Requirements
- R1: After power-on reset the controller is in Reset, the latched instruction is 3'b001 (identity), the serial output enable is low and the float request is low.
- R2: Five consecutive rising test-clock edges with the mode input at 1 bring the controller to Reset from any state.
- R3: The controller moves between its sixteen states on rising test-clock edges, following the transition rules listed above.
- R4: The serial output enable is high exactly while the controller is in DR-shift or IR-shift. The serial output and its enable change only on falling test-clock edges.
- R5: IR-capture loads 3'b001 into the instruction shift stage. Shifting enters at bit 0 and leaves from bit 2. IR-update copies the shift stage into the latched instruction.
- R6: Codes 0, 3, 5, 6 and 7 select a 1-bit path that captures 0 and delays the serial input by one shift.
- R7: Code 1 selects a 32-bit word with bit 0 = 1, bits 11:1 = 11'b00001110001, bits 27:12 = 0 and bits 31:28 = the revision parameter (default 4'h2), which gives 32'h200000E3.
- R8: Codes 2 and 4 select a 70-bit chain. It captures {5'b00000, pin_sample[64:0]}, so the five top cells always read 0, and bit 69 leaves first.
- R9: The float request is high while code 2 is latched and the controller is not in Reset. It is low otherwise, and it rises only after an IR-update.
- R10: Every data path shifts toward its top bit. After a path has emptied its captured bits, the bits that were shifted in leave in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mode_sel | input | 1 | Controller steering input, sampled on rising edge |
| scan_in | input | 1 | Serial data input, sampled on rising edge |
| pin_sample | input | 65 | Sampled device pin values |
| scan_out | output | 1 | Serial data output, updated on falling edge |
| scan_out_en | output | 1 | Serial output driver enable |
| data_hiz | output | 1 | Request to float the memory data pins |

## Verification
The hardest condition to reach from the ports is leaving the float instruction through the five-ones escape partway through a data scan. The float request must survive DR-update and both select states, then drop exactly on the fifth edge. Directed sequences load code 2 and stop inside DR-shift, then count the ones edge by edge. A long random walk on the mode input is checked against a bench model of the controller through the output enable. Random instruction codes and random pin vectors are checked against expected words that the bench computes.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_ID,
        PATH_BND
    } dr_path_t;

    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_IDENT  = 3'd1;
    localparam logic [OP_W-1:0] OP_FLOAT  = 3'd2;
    localparam logic [OP_W-1:0] OP_SAMPLE = 3'd4;
    localparam logic [OP_W-1:0] IR_CAPTURE_PAT = 3'b001;

    function automatic dr_path_t decode_path(input logic [OP_W-1:0] op);
        dr_path_t p;
        case (op)
            OP_IDENT:            p = PATH_ID;
            OP_FLOAT, OP_SAMPLE: p = PATH_BND;
            default:             p = PATH_BYP;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import mtp_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       mode_sel,
    output tap_state_t state,
    output logic       in_reset,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir,
    output logic       cap_dr,
    output logic       shf_dr
);

    tap_state_t nxt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_RESET;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_RESET:  nxt = mode_sel ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = mode_sel ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = mode_sel ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = mode_sel ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = mode_sel ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = mode_sel ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = mode_sel ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = mode_sel ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = mode_sel ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = mode_sel ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = mode_sel ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = mode_sel ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = mode_sel ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = mode_sel ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = mode_sel ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt = mode_sel ? ST_SEL_DR : ST_IDLE;
        endcase
    end

    always_comb begin
        in_reset = (state == ST_RESET);
        cap_ir   = (state == ST_CAP_IR);
        shf_ir   = (state == ST_SHF_IR);
        upd_ir   = (state == ST_UPD_IR);
        cap_dr   = (state == ST_CAP_DR);
        shf_dr   = (state == ST_SHF_DR);
    end

    // R2
    five_ones_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        (mode_sel && $past(mode_sel) && $past(mode_sel, 2) && $past(mode_sel, 3)
         && $past(mode_sel, 4)) |=> (state == ST_RESET));

    // R3
    shift_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((state == ST_SHF_DR) && !mode_sel) |=> (state == ST_SHF_DR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import mtp_pkg::*;
#(
    parameter int              W       = OP_W,
    parameter logic [W-1:0]    CAP_PAT = IR_CAPTURE_PAT,
    parameter logic [W-1:0]    RST_OP  = OP_IDENT
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         in_reset,
    input  logic         cap,
    input  logic         shf,
    input  logic         upd,
    input  logic         scan_in,
    output logic         ir_tail,
    output logic [W-1:0] ir_op
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)   sr_q <= '0;
        else if (cap) sr_q <= CAP_PAT;
        else if (shf) sr_q <= {sr_q[W-2:0], scan_in};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        ir_op <= RST_OP;
        else if (in_reset) ir_op <= RST_OP;
        else if (upd)      ir_op <= sr_q;
    end

    assign ir_tail = sr_q[W-1];

    // R5
    ir_capture_chk: assert property (@(posedge clk) disable iff (!por_n)
        cap |=> (sr_q == CAP_PAT));

    // R5
    ir_update_chk: assert property (@(posedge clk) disable iff (!por_n)
        (upd && !in_reset) |=> (ir_op == $past(sr_q)));

    // R1
    ir_reset_op_chk: assert property (@(posedge clk) disable iff (!por_n)
        in_reset |=> (ir_op == RST_OP));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import mtp_pkg::*;
#(
    parameter int          PIN_W  = 65,
    parameter int          HOLD_W = 5,
    parameter logic [31:0] ID_VAL = 32'h0000_0001,
    localparam int         BSR_W  = PIN_W + HOLD_W,
    localparam int         ID_W   = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  dr_path_t         path,
    input  logic             cap,
    input  logic             shf,
    input  logic             scan_in,
    input  logic [PIN_W-1:0] pin_sample,
    output logic             dr_tail
);

    logic             byp_q;
    logic [ID_W-1:0]  id_q;
    logic [BSR_W-1:0] bsr_q;
    logic [BSR_W-1:0] cap_vec;

    generate
        if (HOLD_W > 0) begin : g_hold
            assign cap_vec = {{HOLD_W{1'b0}}, pin_sample};
        end else begin : g_nohold
            assign cap_vec = pin_sample;
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            byp_q <= 1'b0;
            id_q  <= '0;
            bsr_q <= '0;
        end else begin
            unique case (path)
                PATH_BYP: begin
                    if (cap)      byp_q <= 1'b0;
                    else if (shf) byp_q <= scan_in;
                end
                PATH_ID: begin
                    if (cap)      id_q <= ID_VAL;
                    else if (shf) id_q <= {id_q[ID_W-2:0], scan_in};
                end
                PATH_BND: begin
                    if (cap)      bsr_q <= cap_vec;
                    else if (shf) bsr_q <= {bsr_q[BSR_W-2:0], scan_in};
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (path)
            PATH_ID:  dr_tail = id_q[ID_W-1];
            PATH_BND: dr_tail = bsr_q[BSR_W-1];
            default:  dr_tail = byp_q;
        endcase
    end

    // R6
    bypass_delay_chk: assert property (@(posedge clk) disable iff (!por_n)
        (shf && path == PATH_BYP) |=> (byp_q == $past(scan_in)));

    // R7
    ident_capture_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cap && path == PATH_ID) |=> (id_q[0] == 1'b1));

    // R8
    hold_cells_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cap && path == PATH_BND) |=> (bsr_q[BSR_W-1:PIN_W] == '0));

endmodule

// File: rtl/mem_test_port.sv
module mem_test_port
    import mtp_pkg::*;
#(
    parameter int         PIN_W  = 65,
    parameter int         HOLD_W = 5,
    parameter logic [3:0] ID_REV = 4'h2
) (
    input  logic             test_clk,
    input  logic             por_n,
    input  logic             mode_sel,
    input  logic             scan_in,
    input  logic [PIN_W-1:0] pin_sample,
    output logic             scan_out,
    output logic             scan_out_en,
    output logic             data_hiz
);

    localparam logic [31:0] ID_WORD = {ID_REV, 16'h0000, 11'b000_0111_0001, 1'b1};

    tap_state_t     state;
    logic           in_reset, cap_ir, shf_ir, upd_ir, cap_dr, shf_dr;
    logic           ir_tail, dr_tail;
    logic [OP_W-1:0] ir_op;
    dr_path_t       path;

    tap_fsm u_fsm (
        .clk      (test_clk),
        .por_n    (por_n),
        .mode_sel (mode_sel),
        .state    (state),
        .in_reset (in_reset),
        .cap_ir   (cap_ir),
        .shf_ir   (shf_ir),
        .upd_ir   (upd_ir),
        .cap_dr   (cap_dr),
        .shf_dr   (shf_dr)
    );

    tap_ir u_ir (
        .clk      (test_clk),
        .por_n    (por_n),
        .in_reset (in_reset),
        .cap      (cap_ir),
        .shf      (shf_ir),
        .upd      (upd_ir),
        .scan_in  (scan_in),
        .ir_tail  (ir_tail),
        .ir_op    (ir_op)
    );

    assign path = decode_path(ir_op);

    tap_dr #(
        .PIN_W  (PIN_W),
        .HOLD_W (HOLD_W),
        .ID_VAL (ID_WORD)
    ) u_dr (
        .clk        (test_clk),
        .por_n      (por_n),
        .path       (path),
        .cap        (cap_dr),
        .shf        (shf_dr),
        .scan_in    (scan_in),
        .pin_sample (pin_sample),
        .dr_tail    (dr_tail)
    );

    always_ff @(negedge test_clk or negedge por_n) begin
        if (!por_n) begin
            scan_out    <= 1'b0;
            scan_out_en <= 1'b0;
        end else begin
            scan_out_en <= shf_ir | shf_dr;
            scan_out    <= shf_ir ? ir_tail : dr_tail;
        end
    end

    assign data_hiz = (ir_op == OP_FLOAT) && !in_reset;

    // R4
    out_enable_state_chk: assert property (@(posedge test_clk) disable iff (!por_n)
        scan_out_en == (state == ST_SHF_DR || state == ST_SHF_IR));

    // R9
    float_rise_chk: assert property (@(posedge test_clk) disable iff (!por_n)
        $rose(data_hiz) |-> ($past(state) == ST_UPD_IR));

endmodule

// File: tb/mem_test_port_bench.sv
module mem_test_port_bench;

    localparam int PIN_W = 65;
    localparam int BSR_W = 70;
    localparam logic [31:0] EXP_ID = 32'h2000_00E3;

    logic             test_clk = 1'b0;
    logic             por_n = 1'b0;
    logic             mode_sel = 1'b1;
    logic             scan_in = 1'b0;
    logic [PIN_W-1:0] pin_sample = '0;
    logic             scan_out, scan_out_en, data_hiz;

    int checks = 0;
    int errors = 0;
    int edge_err = 0;
    int seed_dummy;

    mem_test_port u_mem_test_port (
        .test_clk    (test_clk),
        .por_n       (por_n),
        .mode_sel    (mode_sel),
        .scan_in     (scan_in),
        .pin_sample  (pin_sample),
        .scan_out    (scan_out),
        .scan_out_en (scan_out_en),
        .data_hiz    (data_hiz)
    );

    always #5 test_clk = ~test_clk;

    task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic t, input logic d);
        logic hold;
        mode_sel = t;
        scan_in  = d;
        hold = scan_out;
        @(posedge test_clk);
        #1;
        if (scan_out !== hold) edge_err++;
        @(negedge test_clk);
        #1;
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
        tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cap[2-i] = scan_out;
            tick(i == 2, op[2-i]);
        end
        tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    endtask

    task automatic scan_dr(input int n, input logic [159:0] din, output logic [159:0] dout);
        dout = '0;
        tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            dout[n-1-i] = scan_out;
            tick(i == n - 1, din[n-1-i]);
        end
        tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    endtask

    function automatic int next_st(input int s, input logic t);
        case (s)
            0: return t ? 0 : 1;
            1: return t ? 2 : 1;
            2: return t ? 9 : 3;
            3: return t ? 5 : 4;
            4: return t ? 5 : 4;
            5: return t ? 8 : 6;
            6: return t ? 7 : 6;
            7: return t ? 8 : 4;
            8: return t ? 2 : 1;
            9: return t ? 0 : 10;
            10: return t ? 12 : 11;
            11: return t ? 12 : 11;
            12: return t ? 15 : 13;
            13: return t ? 14 : 13;
            14: return t ? 15 : 11;
            default: return t ? 2 : 1;
        endcase
    endfunction

    function automatic logic [159:0] rnd160();
        return {$urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0]   ircap;
        logic [159:0] din, dout, expv;
        logic [PIN_W-1:0] pins;
        int st;
        seed_dummy = $urandom(32'h5eed_1234);

        // R1: reset state
        #23;
        check("R1 enable", {159'b0, scan_out_en}, 160'd0);
        check("R1 float", {159'b0, data_hiz}, 160'd0);
        @(negedge test_clk); #1;
        por_n = 1'b1;
        tick(1'b0, 1'b0);
        // R1 R7: identity word selected after reset
        scan_dr(32, '0, dout);
        check("R1 R7 ident", dout, {128'b0, EXP_ID});

        // R5: captured instruction pattern
        load_ir(3'd4, ircap);
        check("R5 ir capture", {157'b0, ircap}, {157'b0, 3'b001});
        load_ir(3'd1, ircap);
        check("R5 ir shifted out", {157'b0, ircap}, {157'b0, 3'b001});
        scan_dr(32, rnd160(), dout);
        check("R7 ident reload", dout, {128'b0, EXP_ID});

        // R6: every pass-through code
        for (int k = 0; k < 5; k++) begin
            logic [2:0] op;
            op = (k == 0) ? 3'd0 : (k == 1) ? 3'd3 : (k == 2) ? 3'd5 : (k == 3) ? 3'd6 : 3'd7;
            load_ir(op, ircap);
            din = {144'b0, 16'($urandom)};
            scan_dr(16, din, dout);
            check("R6 bypass", dout, din >> 1);
            check("R9 float low", {159'b0, data_hiz}, 160'd0);
        end

        // R8: sample code with random pins
        for (int k = 0; k < 4; k++) begin
            pins = PIN_W'(rnd160());
            pin_sample = pins;
            load_ir(3'd4, ircap);
            scan_dr(BSR_W, '0, dout);
            check("R8 sample", dout, {90'b0, 5'b0, pins});
            check("R9 float off for sample", {159'b0, data_hiz}, 160'd0);
        end

        // R8 R9 R10: float code, chain pass-through after capture
        pins = '1;
        pin_sample = pins;
        load_ir(3'd2, ircap);
        check("R9 float on", {159'b0, data_hiz}, 160'd1);
        din = rnd160();
        din[159:140] = '0;
        scan_dr(140, din, dout);
        expv = '0;
        expv[139:70] = {5'b0, pins};
        expv[69:0]   = din[139:70];
        check("R8 R10 chain", dout, expv);
        check("R9 float held", {159'b0, data_hiz}, 160'd1);

        // R2 R9: five ones from inside DR-shift
        tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
        check("R4 enable in shift", {159'b0, scan_out_en}, 160'd1);
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b0);
        check("R2 float before fifth", {159'b0, data_hiz}, 160'd1);
        tick(1'b1, 1'b0);
        check("R2 R9 float cleared", {159'b0, data_hiz}, 160'd0);
        tick(1'b0, 1'b0);
        scan_dr(32, '0, dout);
        check("R2 R1 ident after escape", dout, {128'b0, EXP_ID});

        // R3 R4: random walk against bench controller model
        to_idle();
        st = 1;
        for (int i = 0; i < 1500; i++) begin
            logic t;
            t = ($urandom % 3) == 0;
            tick(t, 1'($urandom));
            st = next_st(st, t);
            check("R3 R4 enable", {159'b0, scan_out_en},
                  {159'b0, (st == 4 || st == 11)});
        end

        // R4: serial output never moved at a rising edge
        check("R4 falling edge only", 160'(edge_err), 160'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule